// File: doc/BRIEF.md
# Programmable Period and Duty Divider

This block runs on a fast base clock (2.5 ns period, 400 MHz) and derives a slower periodic signal. Software-visible inputs set the period and the high time, both counted in base-clock cycles, and both can be changed while the block runs. The divided level leaves the block straight from a single flip-flop, so it cannot glitch. A one-cycle clock-enable pulse marks each output period, so downstream logic can stay on the base clock and gate on the enable. That is the preferred way to use the block; using the divided level as a clock is the alternative.

New settings are presented with a load strobe. They are held in shadow registers and take over only when a fresh output period begins, so no truncated or stretched pulse ever appears. A phase-start marker shows which period is the first to run with fresh settings. Illegal settings are folded onto legal ones: periods shorter than two cycles run as two, high times of zero give a constant low, and high times at or above the period give a constant high.

Top module: `prog_clk_div`

## Requirements
- R1: Within each output period of P base cycles, `div_clk_o` is high for the first H cycles (starting in the cycle where `ce_o` is 1) and low for the remaining P-H cycles.
- R2: `ce_o` is 1 for exactly one base cycle per output period, and consecutive pulses are exactly P base cycles apart.
- R3: `ce_o` is 1 in the base cycle in which `div_clk_o` first shows its high level for a period; `div_clk_o` never rises in any other cycle, and `ce_o` still pulses when H is 0.
- R4: With H = 0, `div_clk_o` stays low for the whole period; with H >= P, it stays high for the whole period.
- R5: A loaded period value of 0 or 1 is run as a period of 2.
- R6: Values sampled on a clock edge with `load_i` high are kept aside and govern the first period that begins at a later edge; the period in progress keeps its old period and high time.
- R7: `phase_start_o` is 1 together with `ce_o` in the first period after reset and in the first period that uses newly loaded values; it is 0 in all other cycles.
- R8: While `rst_ni` is low, `div_clk_o`, `ce_o` and `phase_start_o` are 0; on the first clock edge after release a period begins with the defaults `DEF_PERIOD` (4) and `DEF_HIGH` (2).
- R9: With the default 12-bit counter, periods up to 4095 base cycles run correctly, covering 1.5 MHz (at least 267 cycles) and below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock (400 MHz nominal) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| period_i | input | CNT_W | Requested period in base cycles |
| high_i | input | CNT_W | Requested high time in base cycles |
| load_i | input | 1 | Captures `period_i` and `high_i` into the shadow registers |
| div_clk_o | output | 1 | Divided level, driven by one flip-flop |
| ce_o | output | 1 | One-cycle enable at the start of each output period |
| phase_start_o | output | 1 | Marks the first period after reset or after new settings |

## Verification
The main function is tried with a table of period and high-time pairs. Balanced and skewed duties separate a correct high count from an off-by-one at either end of the period. Pairs with H of zero and H at or above P show whether the level is held constant while the enable keeps firing. Periods of 0 and 1 show the clamp to 2, and a 300-cycle period shows that the counter is wide enough for the lowest frequency. A load issued in the middle of a period shows whether the running period finishes untouched and the new values start exactly at the next enable, together with the phase-start marker. A reset in the middle of a run shows that the outputs drop at once and that the defaults return.

// File: rtl/prog_clk_div_pkg.sv
package prog_clk_div_pkg;
  localparam int unsigned MIN_PERIOD = 2;
endpackage

// File: rtl/pcd_cfg.sv
// Shadow and active settings; shadow moves to active at a period boundary.
module pcd_cfg
  import prog_clk_div_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter int unsigned DEF_PER  = 4,
  parameter int unsigned DEF_HIGH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] high_i,
  input  logic         wrap_i,
  output logic [W-1:0] act_per_o,
  output logic [W-1:0] act_high_o,
  output logic [W-1:0] nxt_high_o,
  output logic         pend_o
);
  logic [W-1:0] per_c, high_c;
  logic [W-1:0] shd_per_q, shd_high_q, act_per_q, act_high_q;
  logic         pend_q;

  always_comb begin
    per_c  = (period_i < W'(MIN_PERIOD)) ? W'(MIN_PERIOD) : period_i;
    high_c = (high_i > per_c) ? per_c : high_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_per_q  <= W'(DEF_PER);
      shd_high_q <= W'(DEF_HIGH);
      pend_q     <= 1'b0;
    end else if (load_i) begin
      shd_per_q  <= per_c;
      shd_high_q <= high_c;
      pend_q     <= 1'b1;
    end else if (wrap_i) begin
      pend_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_per_q  <= W'(DEF_PER);
      act_high_q <= W'(DEF_HIGH);
    end else if (wrap_i && pend_q) begin
      act_per_q  <= shd_per_q;
      act_high_q <= shd_high_q;
    end
  end

  assign act_per_o  = act_per_q;
  assign act_high_o = act_high_q;
  assign nxt_high_o = pend_q ? shd_high_q : act_high_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/pcd_cnt.sv
// Position counter of the cycle currently shown on the outputs.
module pcd_cnt #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         first_o
);
  logic [W-1:0] cnt_q;
  logic         started_q;

  assign first_o = !started_q;
  assign wrap_o  = first_o || (cnt_q == per_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      started_q <= 1'b1;
      cnt_q     <= wrap_o ? '0 : cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pcd_gen.sv
// Output flops: level, enable and phase marker are all registered.
module pcd_gen #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wrap_i,
  input  logic         fresh_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] high_act_i,
  input  logic [W-1:0] high_nxt_i,
  output logic         div_o,
  output logic         ce_o,
  output logic         ps_o
);
  logic [W:0] cnt_inc;
  logic       div_d;
  logic       div_q, ce_q, ps_q;

  always_comb begin
    cnt_inc = {1'b0, cnt_i} + 1'b1;
    div_d   = wrap_i ? (high_nxt_i != '0) : (cnt_inc < {1'b0, high_act_i});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= 1'b0;
      ce_q  <= 1'b0;
      ps_q  <= 1'b0;
    end else begin
      div_q <= div_d;
      ce_q  <= wrap_i;
      ps_q  <= wrap_i && fresh_i;
    end
  end

  assign div_o = div_q;
  assign ce_o  = ce_q;
  assign ps_o  = ps_q;
endmodule

// File: rtl/prog_clk_div.sv
module prog_clk_div #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned DEF_PERIOD = 4,
  parameter int unsigned DEF_HIGH   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic             load_i,
  output logic             div_clk_o,
  output logic             ce_o,
  output logic             phase_start_o
);
  logic [CNT_W-1:0] act_per, act_high, nxt_high, cnt;
  logic             pend, wrap, first;

  pcd_cfg #(.W(CNT_W), .DEF_PER(DEF_PERIOD), .DEF_HIGH(DEF_HIGH)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .period_i   (period_i),
    .high_i     (high_i),
    .wrap_i     (wrap),
    .act_per_o  (act_per),
    .act_high_o (act_high),
    .nxt_high_o (nxt_high),
    .pend_o     (pend)
  );

  pcd_cnt #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .per_i   (act_per),
    .cnt_o   (cnt),
    .wrap_o  (wrap),
    .first_o (first)
  );

  pcd_gen #(.W(CNT_W)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wrap_i     (wrap),
    .fresh_i    (first || pend),
    .cnt_i      (cnt),
    .high_act_i (act_high),
    .high_nxt_i (nxt_high),
    .div_o      (div_clk_o),
    .ce_o       (ce_o),
    .ps_o       (phase_start_o)
  );
endmodule

// File: rtl/prog_clk_div_chk.sv
module prog_clk_div_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic div_clk_o,
  input logic ce_o,
  input logic phase_start_o
);
  // R2: period is at least two cycles, so an enable never repeats back to back
  a_r2_ce_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_o |=> !ce_o);

  // R3: the level may only rise together with the enable
  a_r3_rise_with_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_clk_o && !$past(div_clk_o)) |-> ce_o);

  // R7: the phase marker is a subset of the enable
  a_r7_ps_implies_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_start_o |-> ce_o);

  // R8: outputs held low while reset is asserted
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_low: assert (!div_clk_o && !ce_o && !phase_start_o);
    end
  end
endmodule

bind prog_clk_div prog_clk_div_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .div_clk_o     (div_clk_o),
  .ce_o          (ce_o),
  .phase_start_o (phase_start_o)
);

// File: tb/prog_clk_div_bench.sv
module prog_clk_div_bench;
  localparam int unsigned CNT_W = 12;
  localparam int unsigned NVEC  = 10;
  // requested period, requested high, expected period, expected high
  localparam int unsigned VEC [NVEC][4] = '{
    '{10, 5, 10, 5}, '{7, 2, 7, 2}, '{9, 0, 9, 0}, '{6, 6, 6, 6},
    '{5, 9, 5, 5},   '{1, 1, 2, 1}, '{0, 0, 2, 0}, '{300, 100, 300, 100},
    '{2, 1, 2, 1},   '{3, 2, 3, 2}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] period = '0;
  logic [CNT_W-1:0] high = '0;
  logic             load = 1'b0;
  logic             div_clk, ce, ps;
  int               n_chk = 0;
  int               n_err = 0;

  always #2 clk = ~clk;

  prog_clk_div #(.CNT_W(CNT_W), .DEF_PERIOD(4), .DEF_HIGH(2)) u_prog_clk_div (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .period_i      (period),
    .high_i        (high),
    .load_i        (load),
    .div_clk_o     (div_clk),
    .ce_o          (ce),
    .phase_start_o (ps)
  );

  task automatic check(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic load_cfg(input int p, input int h);
    @(negedge clk);
    period = CNT_W'(p);
    high   = CNT_W'(h);
    load   = 1'b1;
    @(negedge clk);
    load   = 1'b0;
  endtask

  // Waits until the phase marker is seen; returns in that cycle.
  task automatic wait_ps(input string req);
    int k = 0;
    while (!ps && k < 5000) begin
      @(negedge clk);
      k++;
    end
    check(req, int'(ps), 1, "phase_start seen");
  endtask

  // Called in the cycle with ce=1 of a period; ends in the ce cycle of the next one.
  task automatic measure(input string req, input int ep, input int eh);
    int hi = 0;
    int extra_ce = 0;
    check("R3", int'(div_clk), (eh > 0) ? 1 : 0, "level in enable cycle");
    for (int i = 0; i < ep; i++) begin
      if (i > 0) @(negedge clk);
      if (div_clk) hi++;
      if (i > 0 && ce) extra_ce++;
      if (i > 0 && div_clk && hi != i + 1) extra_ce++;
    end
    @(negedge clk);
    check({req, "/R1"}, hi, eh, "high cycles per period");
    check("R2", extra_ce, 0, "spurious enable or late rise");
    check("R2", int'(ce), 1, "enable after full period");
    check("R7", int'(ps), 0, "no marker without load");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8", int'(div_clk), 0, "div low in reset");
    check("R8", int'(ce), 0, "ce low in reset");
    check("R8", int'(ps), 0, "ps low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", int'(ps), 1, "marker in first period");
    check("R8", int'(ce), 1, "period starts at first edge");
    measure("R8", 4, 2);

    // Table: R1 R2 R4 R5 R9
    for (int v = 0; v < NVEC; v++) begin
      load_cfg(int'(VEC[v][0]), int'(VEC[v][1]));
      wait_ps("R6");
      measure((VEC[v][1] == 0 || VEC[v][1] >= VEC[v][2]) ? "R4" :
              (VEC[v][0] < 2) ? "R5" : (VEC[v][0] > 255) ? "R9" : "R1",
              int'(VEC[v][2]), int'(VEC[v][3]));
    end

    // R6: load mid-period does not disturb the running period
    load_cfg(8, 3);
    wait_ps("R6");
    measure("R6", 8, 3);
    begin
      int hi = 0;
      int bad = 0;
      @(negedge clk);
      period = CNT_W'(5);
      high   = CNT_W'(1);
      load   = 1'b1;
      @(negedge clk);
      load   = 1'b0;
      for (int i = 2; i < 8; i++) begin
        if (i > 2) @(negedge clk);
        if (div_clk) hi++;
        if (ce || ps) bad++;
      end
      check("R6", hi, 1, "old high time kept after load");
      check("R6", bad, 0, "no early enable after load");
      @(negedge clk);
      check("R6", int'(ce), 1, "old period length kept");
      check("R7", int'(ps), 1, "marker with new values");
      measure("R6", 5, 1);
    end

    // R8: asynchronous reset mid-run, then defaults return
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8", int'(div_clk | ce | ps), 0, "outputs drop in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7", int'(ps), 1, "marker after reset");
    measure("R8", 4, 2);

    finish_run();
  end
endmodule